// File: doc/BRIEF.md
# Indirect Memory Access Window

The window lets a host reach a large internal SRAM and a space of peripheral registers through a handful of 32-bit host registers. The host first loads an address register and then reads or writes the matching data register. On the SRAM side, reads and writes keep separate pointers, and each data access moves its pointer forward by one dword (4 bytes). Sequential blocks therefore need only one address write.

Reads are prefetched. Loading the SRAM read pointer starts a memory read at once. Each accepted read of the SRAM read-data register returns the word already buffered and starts the fetch of the next word. On the peripheral side, the address registers also carry a byte count. Peripheral accesses never advance their address. A peripheral write drives byte enables only for the low bytes covered by the count.

The host port is a valid/ready register port. An access completes in the cycle where `host_valid` and `host_ready` are both high, and read data is presented in that same cycle. `host_ready` drops only while a read is still outstanding on a path and the host either reads that path's read-data register or reloads its read-address register. The host must then hold its request stable until ready returns. Both internal ports are synchronous and always accept a request. Read responses come back with a valid strobe after any latency of at least one cycle. At most one read is outstanding per path.

Top module: `imw_window`

## Requirements
- R1: Host offsets decode as follows: SRAM read address 0x0C, SRAM write address 0x10, SRAM write data 0x18, SRAM read data 0x1C, peripheral write address 0x44, peripheral read address 0x48, peripheral write data 0x4C, peripheral read data 0x50. A read of any other offset, or of a write-data offset, returns 0. A write to any other offset changes no state and issues no request. No internal request is ever issued without an accepted host access.
- R2: After reset, both SRAM pointers and both peripheral address registers read 0, `host_ready` is 1, and `mem_req` and `prph_req` are 0.
- R3: A write to SRAM write data issues a memory write of the host data, in the same cycle, to the write pointer. The write pointer then advances by 4.
- R4: A write to SRAM read address issues a memory read, in the same cycle, at the written address and loads that address into the read pointer.
- R5: An accepted read of SRAM read data returns the buffered word at the read pointer. In the same cycle it issues a memory read at pointer+4, and the pointer advances by 4.
- R6: While an SRAM or peripheral read is outstanding, `host_ready` is 0 for a read of that path's read-data register and for a write to its read-address register. Otherwise `host_ready` is 1. A read of SRAM read data is never accepted in the cycle right after another one.
- R7: The SRAM read and write pointers are independent, and interleaved accesses leave each intact. Reading an SRAM address register returns its pointer: the next write target, or the address of the word the next data read returns.
- R8: In a peripheral address register, bits 15:0 hold the register offset and bits 25:24 hold the byte count minus one. Reading the register back returns only those fields, with all other bits 0.
- R9: A peripheral write issues `prph_be` with the low count bytes set (0001, 0011, 0111 or 1111) at the stored address. Only those bytes change, and the address does not advance.
- R10: A write to peripheral read address issues a peripheral read at that offset. Peripheral read data then returns the response with bytes above the count cleared. Repeated reads return the same word without a new request.
- R11: SRAM pointers wrap modulo 2^32, so a pointer at 0xFFFFFFFC advances to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host access request |
| host_ready | output | 1 | Access accepted when high with host_valid |
| host_we | input | 1 | 1 write, 0 read |
| host_off | input | 8 | Register offset in the window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid in the accept cycle |
| mem_req | output | 1 | SRAM request |
| mem_we | output | 1 | SRAM write when 1 |
| mem_addr | output | 32 | SRAM byte address |
| mem_wdata | output | 32 | SRAM write data |
| mem_rvalid | input | 1 | SRAM read response strobe |
| mem_rdata | input | 32 | SRAM read response |
| prph_req | output | 1 | Peripheral request |
| prph_we | output | 1 | Peripheral write when 1 |
| prph_addr | output | 16 | Peripheral register offset |
| prph_be | output | 4 | Peripheral byte enables |
| prph_wdata | output | 32 | Peripheral write data |
| prph_rvalid | input | 1 | Peripheral read response strobe |
| prph_rdata | input | 32 | Peripheral read response |

## Verification
The bench builds the window with its default parameters: a 32-bit SRAM address, a 16-bit peripheral offset and an 8-bit host offset. The full address width makes the wrap from 0xFFFFFFFC to 0 reachable with a small memory model that decodes only the low address bits. The SRAM model answers after three cycles, so every back-to-back data read and every early read after a pointer load meets the stall. The peripheral model answers after one cycle, which exercises the shortest pending window and all four byte counts.

// File: rtl/imw_pkg.sv
package imw_pkg;
  localparam int HOST_DW  = 32;
  localparam int BYTES    = HOST_DW / 8;
  localparam int CNT_LSB  = 24;

  localparam logic [7:0] OFF_M_RADDR = 8'h0C;
  localparam logic [7:0] OFF_M_WADDR = 8'h10;
  localparam logic [7:0] OFF_M_WDAT  = 8'h18;
  localparam logic [7:0] OFF_M_RDAT  = 8'h1C;
  localparam logic [7:0] OFF_P_WADDR = 8'h44;
  localparam logic [7:0] OFF_P_RADDR = 8'h48;
  localparam logic [7:0] OFF_P_WDAT  = 8'h4C;
  localparam logic [7:0] OFF_P_RDAT  = 8'h50;

  typedef struct packed {
    logic m_raddr;
    logic m_waddr;
    logic m_wdat;
    logic m_rdat;
    logic p_waddr;
    logic p_raddr;
    logic p_wdat;
    logic p_rdat;
  } win_sel_t;

  // byte enables for a count field holding (bytes - 1)
  function automatic logic [BYTES-1:0] cnt_to_be(input logic [1:0] cnt);
    logic [BYTES-1:0] be;
    for (int i = 0; i < BYTES; i++) be[i] = (i <= int'(cnt));
    return be;
  endfunction

  function automatic logic [HOST_DW-1:0] keep_low_bytes(input logic [HOST_DW-1:0] d,
                                                       input logic [1:0] cnt);
    logic [BYTES-1:0] be;
    logic [HOST_DW-1:0] r;
    be = cnt_to_be(cnt);
    for (int i = 0; i < BYTES; i++) r[i*8 +: 8] = be[i] ? d[i*8 +: 8] : 8'h00;
    return r;
  endfunction
endpackage

// File: rtl/imw_decode.sv
module imw_decode
  import imw_pkg::*;
#(
  parameter int OFF_W = 8
) (
  input  logic [OFF_W-1:0] off,
  output win_sel_t         sel
);
  always_comb begin
    sel         = '0;
    sel.m_raddr = (off == OFF_W'(OFF_M_RADDR));
    sel.m_waddr = (off == OFF_W'(OFF_M_WADDR));
    sel.m_wdat  = (off == OFF_W'(OFF_M_WDAT));
    sel.m_rdat  = (off == OFF_W'(OFF_M_RDAT));
    sel.p_waddr = (off == OFF_W'(OFF_P_WADDR));
    sel.p_raddr = (off == OFF_W'(OFF_P_RADDR));
    sel.p_wdat  = (off == OFF_W'(OFF_P_WDAT));
    sel.p_rdat  = (off == OFF_W'(OFF_P_RDAT));
  end
endmodule

// File: rtl/imw_sram_path.sv
module imw_sram_path
  import imw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_waddr,
  input  logic               ld_raddr,
  input  logic               put_data,
  input  logic               take_data,
  input  logic [HOST_DW-1:0] wdata,
  output logic [AW-1:0]      wr_ptr,
  output logic [AW-1:0]      rd_ptr,
  output logic [HOST_DW-1:0] rd_buf,
  output logic               rd_pend,
  output logic               mem_req,
  output logic               mem_we,
  output logic [AW-1:0]      mem_addr,
  output logic [HOST_DW-1:0] mem_wdata,
  input  logic               mem_rvalid,
  input  logic [HOST_DW-1:0] mem_rdata
);
  localparam logic [AW-1:0] STEP = AW'(BYTES);

  logic [AW-1:0] rd_next;
  assign rd_next = rd_ptr + STEP;

  always_comb begin
    mem_req   = put_data | ld_raddr | take_data;
    mem_we    = put_data;
    mem_wdata = wdata;
    if (put_data)      mem_addr = wr_ptr;
    else if (ld_raddr) mem_addr = wdata[AW-1:0];
    else               mem_addr = rd_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      rd_buf  <= '0;
      rd_pend <= 1'b0;
    end else begin
      if (ld_waddr)      wr_ptr <= wdata[AW-1:0];
      else if (put_data) wr_ptr <= wr_ptr + STEP;

      if (ld_raddr)       rd_ptr <= wdata[AW-1:0];
      else if (take_data) rd_ptr <= rd_next;

      if (mem_rvalid && rd_pend) begin
        rd_buf  <= mem_rdata;
        rd_pend <= 1'b0;
      end
      if (ld_raddr || take_data) rd_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/imw_prph_path.sv
module imw_prph_path
  import imw_pkg::*;
#(
  parameter int PAW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_waddr,
  input  logic               ld_raddr,
  input  logic               put_data,
  input  logic [HOST_DW-1:0] wdata,
  output logic [PAW-1:0]     w_off,
  output logic [1:0]         w_cnt,
  output logic [PAW-1:0]     r_off,
  output logic [1:0]         r_cnt,
  output logic [HOST_DW-1:0] r_buf,
  output logic               r_pend,
  output logic               prph_req,
  output logic               prph_we,
  output logic [PAW-1:0]     prph_addr,
  output logic [BYTES-1:0]   prph_be,
  output logic [HOST_DW-1:0] prph_wdata,
  input  logic               prph_rvalid,
  input  logic [HOST_DW-1:0] prph_rdata
);
  logic [1:0] in_cnt;
  assign in_cnt = wdata[CNT_LSB +: 2];

  always_comb begin
    prph_req   = put_data | ld_raddr;
    prph_we    = put_data;
    prph_wdata = wdata;
    prph_addr  = put_data ? w_off : wdata[PAW-1:0];
    prph_be    = cnt_to_be(put_data ? w_cnt : in_cnt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_off  <= '0;
      w_cnt  <= '0;
      r_off  <= '0;
      r_cnt  <= '0;
      r_buf  <= '0;
      r_pend <= 1'b0;
    end else begin
      if (ld_waddr) begin
        w_off <= wdata[PAW-1:0];
        w_cnt <= in_cnt;
      end
      if (prph_rvalid && r_pend) begin
        r_buf  <= keep_low_bytes(prph_rdata, r_cnt);
        r_pend <= 1'b0;
      end
      if (ld_raddr) begin
        r_off  <= wdata[PAW-1:0];
        r_cnt  <= in_cnt;
        r_pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/imw_window.sv
module imw_window
  import imw_pkg::*;
#(
  parameter int OFF_W = 8,
  parameter int AW    = 32,
  parameter int PAW   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_valid,
  output logic             host_ready,
  input  logic             host_we,
  input  logic [OFF_W-1:0] host_off,
  input  logic [31:0]      host_wdata,
  output logic [31:0]      host_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata,
  output logic             prph_req,
  output logic             prph_we,
  output logic [PAW-1:0]   prph_addr,
  output logic [3:0]       prph_be,
  output logic [31:0]      prph_wdata,
  input  logic             prph_rvalid,
  input  logic [31:0]      prph_rdata
);
  localparam int PAD_P = CNT_LSB - PAW;

  win_sel_t       sel;
  logic           acc, wr, rd;
  logic [AW-1:0]  wr_ptr, rd_ptr;
  logic [31:0]    rd_buf, p_buf;
  logic           rd_pend, p_pend;
  logic [PAW-1:0] pw_off, pr_off;
  logic [1:0]     pw_cnt, pr_cnt;
  logic           m_block, p_block;

  imw_decode #(.OFF_W(OFF_W)) u_dec (.off(host_off), .sel(sel));

  assign m_block    = rd_pend && ((sel.m_rdat && !host_we) || (sel.m_raddr && host_we));
  assign p_block    = p_pend  && ((sel.p_rdat && !host_we) || (sel.p_raddr && host_we));
  assign host_ready = !(m_block || p_block);
  assign acc        = host_valid && host_ready;
  assign wr         = acc && host_we;
  assign rd         = acc && !host_we;

  imw_sram_path #(.AW(AW)) u_sram (
    .clk, .rst_n,
    .ld_waddr  (wr && sel.m_waddr),
    .ld_raddr  (wr && sel.m_raddr),
    .put_data  (wr && sel.m_wdat),
    .take_data (rd && sel.m_rdat),
    .wdata     (host_wdata),
    .wr_ptr, .rd_ptr, .rd_buf, .rd_pend,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rvalid, .mem_rdata
  );

  imw_prph_path #(.PAW(PAW)) u_prph (
    .clk, .rst_n,
    .ld_waddr  (wr && sel.p_waddr),
    .ld_raddr  (wr && sel.p_raddr),
    .put_data  (wr && sel.p_wdat),
    .wdata     (host_wdata),
    .w_off     (pw_off),
    .w_cnt     (pw_cnt),
    .r_off     (pr_off),
    .r_cnt     (pr_cnt),
    .r_buf     (p_buf),
    .r_pend    (p_pend),
    .prph_req, .prph_we, .prph_addr, .prph_be, .prph_wdata, .prph_rvalid, .prph_rdata
  );

  function automatic logic [31:0] pack_paddr(input logic [PAW-1:0] o, input logic [1:0] c);
    return {6'b0, c, {PAD_P{1'b0}}, o};
  endfunction

  always_comb begin
    host_rdata = '0;
    if (sel.m_raddr)      host_rdata = 32'(rd_ptr);
    else if (sel.m_waddr) host_rdata = 32'(wr_ptr);
    else if (sel.m_rdat)  host_rdata = rd_buf;
    else if (sel.p_waddr) host_rdata = pack_paddr(pw_off, pw_cnt);
    else if (sel.p_raddr) host_rdata = pack_paddr(pr_off, pr_cnt);
    else if (sel.p_rdat)  host_rdata = p_buf;
  end
endmodule

// File: rtl/imw_checker.sv
module imw_checker
  import imw_pkg::*;
#(
  parameter int OFF_W = 8,
  parameter int AW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_valid,
  input logic             host_ready,
  input logic             host_we,
  input logic [OFF_W-1:0] host_off,
  input logic [31:0]      host_wdata,
  input logic             mem_req,
  input logic             mem_we,
  input logic [AW-1:0]    mem_addr,
  input logic [31:0]      mem_wdata,
  input logic             prph_req,
  input logic [3:0]       prph_be
);
  logic acc;
  assign acc = host_valid && host_ready;

  // R4
  raddr_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && host_we && host_off == OFF_W'(OFF_M_RADDR))
      |-> (mem_req && !mem_we && mem_addr == host_wdata[AW-1:0]));

  // R5
  rdat_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !host_we && host_off == OFF_W'(OFF_M_RDAT)) |-> (mem_req && !mem_we));

  // R3
  wdat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && host_we && host_off == OFF_W'(OFF_M_WDAT))
      |-> (mem_req && mem_we && mem_wdata == host_wdata));

  // R1
  no_spurious_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || prph_req) |-> acc);

  // R9
  prph_be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prph_req |-> (prph_be == 4'b0001 || prph_be == 4'b0011 ||
                  prph_be == 4'b0111 || prph_be == 4'b1111));

  // R6
  rdat_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !host_we && host_off == OFF_W'(OFF_M_RDAT))
      |=> !(host_valid && host_ready && !host_we && host_off == OFF_W'(OFF_M_RDAT)));
endmodule

bind imw_window imw_checker #(.OFF_W(OFF_W), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_valid (host_valid),
  .host_ready (host_ready),
  .host_we    (host_we),
  .host_off   (host_off),
  .host_wdata (host_wdata),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .prph_req   (prph_req),
  .prph_be    (prph_be)
);

// File: tb/tb_imw_window.sv
module tb_imw_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0;
  logic        host_we = 1'b0;
  logic [7:0]  host_off = '0;
  logic [31:0] host_wdata = '0;
  logic        host_ready;
  logic [31:0] host_rdata;
  logic        mem_req, mem_we, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        prph_req, prph_we, prph_rvalid;
  logic [15:0] prph_addr;
  logic [3:0]  prph_be;
  logic [31:0] prph_wdata, prph_rdata;

  int checks = 0;
  int fails  = 0;
  int stalls = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] mem[64];
  logic [31:0] preg[16];
  logic [3:0]  last_be = '0;

  always #4 clk = ~clk;

  imw_window dut (.*);

  // SRAM model: three-cycle response
  logic        v0 = 0, v1 = 0, v2 = 0;
  logic [31:0] d0 = '0, d1 = '0, d2 = '0;
  assign mem_rvalid = v2;
  assign mem_rdata  = d2;
  always @(posedge clk) begin
    v0 <= mem_req && !mem_we;
    d0 <= mem[mem_addr[7:2]];
    v1 <= v0; d1 <= d0;
    v2 <= v1; d2 <= d1;
    if (mem_req && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
  end

  // peripheral model: one-cycle response
  logic        pv = 0;
  logic [31:0] pd = '0;
  assign prph_rvalid = pv;
  assign prph_rdata  = pd;
  always @(posedge clk) begin
    pv <= prph_req && !prph_we;
    pd <= preg[prph_addr[3:0]];
    if (prph_req && prph_we) begin
      last_be <= prph_be;
      for (int i = 0; i < 4; i++)
        if (prph_be[i]) preg[prph_addr[3:0]][i*8 +: 8] <= prph_wdata[i*8 +: 8];
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compare each accepted read
  always @(negedge clk) begin
    if (rst_n && host_valid && host_ready && !host_we) begin
      if (exp_q.size() == 0) check("scoreboard-empty", 32'h1, 32'h0);
      else check(tag_q.pop_front(), host_rdata, exp_q.pop_front());
    end
  end

  task automatic access(input logic we, input logic [7:0] off, input logic [31:0] d);
    logic r;
    host_valid = 1'b1; host_we = we; host_off = off; host_wdata = d;
    forever begin
      @(negedge clk) r = host_ready;
      if (!r) stalls++;
      @(posedge clk);
      #1;
      if (r) break;
    end
    host_valid = 1'b0;
  endtask

  task automatic hwr(input logic [7:0] off, input logic [31:0] d);
    access(1'b1, off, d);
  endtask

  task automatic hrd(input logic [7:0] off, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    access(1'b0, off, 32'h0);
  endtask

  initial begin
    int s0;
    for (int i = 0; i < 64; i++) mem[i] = 32'hA000_0000 + 32'(i) * 32'h11;
    for (int i = 0; i < 16; i++) preg[i] = 32'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R2 host_ready", {31'b0, host_ready}, 32'h1);
    check("R2 mem_req", {31'b0, mem_req}, 32'h0);
    check("R2 prph_req", {31'b0, prph_req}, 32'h0);
    @(posedge clk); #1;
    hrd(8'h0C, 32'h0, "R2 rd ptr");
    hrd(8'h10, 32'h0, "R2 wr ptr");
    hrd(8'h44, 32'h0, "R2 prph waddr");

    // R3 sequential writes
    hwr(8'h10, 32'h40);
    hwr(8'h18, 32'hD000_0000);
    hwr(8'h18, 32'hD000_0001);
    hwr(8'h18, 32'hD000_0002);
    check("R3 word0", mem[16], 32'hD000_0000);
    check("R3 word1", mem[17], 32'hD000_0001);
    check("R3 word2", mem[18], 32'hD000_0002);
    hrd(8'h10, 32'h4C, "R7 wr ptr readback");

    // R4 R5 R6 sequential prefetched reads
    s0 = stalls;
    hwr(8'h0C, 32'h40);
    hrd(8'h1C, 32'hD000_0000, "R5 rd0");
    hrd(8'h1C, 32'hD000_0001, "R5 rd1");
    hrd(8'h1C, 32'hD000_0002, "R5 rd2");
    check("R6 stalled", {31'b0, (stalls > s0)}, 32'h1);
    hrd(8'h0C, 32'h4C, "R7 rd ptr readback");

    // R7 interleaved pointers
    hwr(8'h10, 32'h80);
    hwr(8'h0C, 32'h10);
    hwr(8'h18, 32'hE000_0000);
    hrd(8'h1C, 32'hA000_0044, "R7 rd mem4");
    hwr(8'h18, 32'hE000_0001);
    hrd(8'h1C, 32'hA000_0055, "R7 rd mem5");
    hwr(8'h0C, 32'h80);
    hrd(8'h1C, 32'hE000_0000, "R7 rd back0");
    hrd(8'h1C, 32'hE000_0001, "R7 rd back1");

    // R11 wrap
    hwr(8'h10, 32'hFFFF_FFFC);
    hwr(8'h18, 32'h5151_0000);
    hwr(8'h18, 32'h5151_0001);
    check("R11 wr top", mem[63], 32'h5151_0000);
    check("R11 wr zero", mem[0], 32'h5151_0001);
    hrd(8'h10, 32'h4, "R11 wr ptr wrapped");
    hwr(8'h0C, 32'hFFFF_FFFC);
    hrd(8'h1C, 32'h5151_0000, "R11 rd top");
    hrd(8'h1C, 32'h5151_0001, "R11 rd zero");

    // R1 unmapped and write-data offsets
    hwr(8'h20, 32'hDEAD_BEEF);
    hrd(8'h20, 32'h0, "R1 unmapped read");
    hrd(8'h18, 32'h0, "R1 wdat read");
    hrd(8'h10, 32'h4, "R1 wr ptr untouched");

    // R8 R9 peripheral writes
    hwr(8'h44, 32'h0300_0005);
    hrd(8'h44, 32'h0300_0005, "R8 paddr fields");
    hwr(8'h4C, 32'h1122_3344);
    check("R9 full write", preg[5], 32'h1122_3344);
    check("R9 be full", {28'b0, last_be}, 32'hF);
    hwr(8'h44, 32'hFCFF_0007);
    hrd(8'h44, 32'h0000_0007, "R8 other bits dropped");
    hwr(8'h44, 32'h0100_0005);
    hwr(8'h4C, 32'hAABB_CCDD);
    check("R9 two bytes", preg[5], 32'h1122_CCDD);
    check("R9 be two", {28'b0, last_be}, 32'h3);
    hwr(8'h4C, 32'h5566_7788);
    check("R9 no advance", preg[5], 32'h1122_7788);
    check("R9 other reg untouched", preg[6], 32'h0);

    // R10 peripheral reads
    hwr(8'h48, 32'h0300_0005);
    hrd(8'h50, 32'h1122_7788, "R10 full read");
    hrd(8'h50, 32'h1122_7788, "R10 repeat read");
    hwr(8'h48, 32'h0000_0005);
    hrd(8'h50, 32'h0000_0088, "R10 one byte");
    hrd(8'h48, 32'h0000_0005, "R8 raddr readback");
    hwr(8'h48, 32'h0200_0005);
    hrd(8'h50, 32'h0022_7788, "R10 three bytes");

    repeat (4) @(posedge clk);
    check("R1 queue drained", 32'(exp_q.size()), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule